// File: doc/BRIEF.md
# Dual Time-of-Day Alarm Matcher

This block watches the calendar and time registers of a real-time clock and compares them with two programmable alarm register sets. The comparison happens only when the timekeeping logic issues its once-per-second update strobe. When a set matches, the block emits a one-cycle set request for that alarm's flag. The flag storage, the register bus and the interrupt pin are outside this block.

The first alarm has four fields: seconds, minutes, hours and a top day/date field. The second alarm has only minutes, hours and day/date. It is treated as if its seconds were 00, so it can fire only while the current seconds value is zero. Bit 7 of every alarm byte is a mask bit, and a masked field takes no part in the compare. The listed mask patterns therefore select how often the alarm repeats. Bit 6 of each day/date alarm byte selects the target of the top field: day of week or date of month.

All fields are packed BCD bytes. The block has no state of its own in the default build. A parameter can add a register stage, which moves the set requests one cycle after the strobe.

Top module: `tod_alarm_match`

## Requirements
- R1: `alm1_hit` and `alm2_hit` are low in every cycle in which `sec_tick` is low.
- R2: With the alarm-1 mask bits (bit 7 of hour/min/sec/day bytes, written day,hour,min,sec) equal to 1111, `alm1_hit` is high on every `sec_tick`.
- R3: With alarm-1 masks 1110 (only seconds unmasked), `alm1_hit` is high on `sec_tick` exactly when bits 6:0 of `alm1_sec` equal bits 6:0 of `now_sec`.
- R4: With alarm-1 masks 1100, both minutes and seconds must match. With 1000, hours, minutes and seconds must match (bits 6:0 of each byte).
- R5: With all alarm-1 masks 0, the day/date field must also match. When bit 6 of `alm1_day` is 0, its bits 5:0 are compared with bits 5:0 of `now_mday`. When bit 6 is 1, they are compared with bits 5:0 of `now_wday`.
- R6: `alm2_hit` can be high only when bits 6:0 of `now_sec` are zero. With alarm-2 masks (day,hour,min) 111, it is high on every `sec_tick` where seconds are 00.
- R7: Alarm-2 masks 110 require a minutes match, 100 require hours and minutes, and 000 additionally require the day/date field selected by bit 6 of `alm2_day`, in the same way as R5.
- R8: Bit 7 of the current-time bytes, and bits 7:6 of the current day/date bytes, never affect a compare. The mask and select bits of an alarm byte are not part of its compare value.
- R9: In the default build (`OUT_STAGE`=0) a set request appears in the same cycle as `sec_tick` and lasts one cycle per strobe.
- R10: The two alarms are evaluated independently: the settings of one have no effect on the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | Once-per-second timekeeping update strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current day of week, BCD |
| now_mday | input | 8 | Current date of month, BCD |
| alm1_sec | input | 8 | Alarm 1 seconds: bit 7 mask, bits 6:0 value |
| alm1_min | input | 8 | Alarm 1 minutes: bit 7 mask, bits 6:0 value |
| alm1_hour | input | 8 | Alarm 1 hours: bit 7 mask, bits 6:0 value |
| alm1_day | input | 8 | Alarm 1 day/date: bit 7 mask, bit 6 select, bits 5:0 value |
| alm2_min | input | 8 | Alarm 2 minutes: bit 7 mask, bits 6:0 value |
| alm2_hour | input | 8 | Alarm 2 hours: bit 7 mask, bits 6:0 value |
| alm2_day | input | 8 | Alarm 2 day/date: bit 7 mask, bit 6 select, bits 5:0 value |
| alm1_hit | output | 1 | Set request for the alarm 1 flag |
| alm2_hit | output | 1 | Set request for the alarm 2 flag |

## Verification
The embedded assertions check four things on every cycle: a hit never appears without the strobe, an alarm-2 hit never appears unless seconds are zero, the fully masked alarm 1 always fires on a strobe, and an alarm-1 hit always agrees with an unmasked seconds field. Other behaviour can only be shown by the bench scenarios, because each case depends on the chosen stimulus. This covers the selection between day of week and date of month, the rejection of near-miss values in single fields, the independence of the two alarms, and the fact that the excluded bits have no effect.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int BYTE_W  = 8;
  localparam int TIME_W  = 7;   // compared bits of sec/min/hour
  localparam int DAY_W   = 6;   // compared bits of day/date
  localparam int MASK_B  = 7;
  localparam int SEL_B   = 6;

  typedef enum logic {DAY_TGT_DATE = 1'b0, DAY_TGT_WEEKDAY = 1'b1} day_tgt_e;
endpackage

// File: rtl/tod_field_cmp.sv
module tod_field_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] alarm_val,
  input  logic [W-1:0] now_val,
  input  logic         masked,
  output logic         field_ok
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = ~(alarm_val[i] ^ now_val[i]);
  end

  assign field_ok = masked | (&bit_eq);
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic [BYTE_W-1:0] now_sec,
  input  logic [BYTE_W-1:0] now_min,
  input  logic [BYTE_W-1:0] now_hour,
  input  logic [BYTE_W-1:0] now_wday,
  input  logic [BYTE_W-1:0] now_mday,
  input  logic [BYTE_W-1:0] cfg_sec,
  input  logic [BYTE_W-1:0] cfg_min,
  input  logic [BYTE_W-1:0] cfg_hour,
  input  logic [BYTE_W-1:0] cfg_day,
  output logic              unit_match
);
  logic             sec_ok, min_ok, hour_ok, day_ok;
  logic [DAY_W-1:0] day_target;
  day_tgt_e         tgt;

  if (HAS_SEC) begin : g_sec_field
    tod_field_cmp #(.W(TIME_W)) u_sec (
      .alarm_val (cfg_sec[TIME_W-1:0]),
      .now_val   (now_sec[TIME_W-1:0]),
      .masked    (cfg_sec[MASK_B]),
      .field_ok  (sec_ok)
    );
  end else begin : g_sec_zero
    logic [BYTE_W-1:0] unused_cfg_sec;
    assign unused_cfg_sec = cfg_sec;
    assign sec_ok = (now_sec[TIME_W-1:0] == '0);
  end

  tod_field_cmp #(.W(TIME_W)) u_min (
    .alarm_val (cfg_min[TIME_W-1:0]),
    .now_val   (now_min[TIME_W-1:0]),
    .masked    (cfg_min[MASK_B]),
    .field_ok  (min_ok)
  );

  tod_field_cmp #(.W(TIME_W)) u_hour (
    .alarm_val (cfg_hour[TIME_W-1:0]),
    .now_val   (now_hour[TIME_W-1:0]),
    .masked    (cfg_hour[MASK_B]),
    .field_ok  (hour_ok)
  );

  always_comb begin
    tgt = day_tgt_e'(cfg_day[SEL_B]);
    if (tgt == DAY_TGT_WEEKDAY) day_target = now_wday[DAY_W-1:0];
    else                        day_target = now_mday[DAY_W-1:0];
  end

  tod_field_cmp #(.W(DAY_W)) u_day (
    .alarm_val (cfg_day[DAY_W-1:0]),
    .now_val   (day_target),
    .masked    (cfg_day[MASK_B]),
    .field_ok  (day_ok)
  );

  assign unit_match = sec_ok & min_ok & hour_ok & day_ok;

  logic unused_hi;
  assign unused_hi = now_sec[BYTE_W-1] ^ now_min[BYTE_W-1] ^ now_hour[BYTE_W-1]
                   ^ (^now_wday[BYTE_W-1:DAY_W]) ^ (^now_mday[BYTE_W-1:DAY_W]);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter bit OUT_STAGE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_wday,
  input  logic [7:0] now_mday,
  input  logic [7:0] alm1_sec,
  input  logic [7:0] alm1_min,
  input  logic [7:0] alm1_hour,
  input  logic [7:0] alm1_day,
  input  logic [7:0] alm2_min,
  input  logic [7:0] alm2_hour,
  input  logic [7:0] alm2_day,
  output logic       alm1_hit,
  output logic       alm2_hit
);
  logic match1, match2;
  logic req1, req2;

  tod_alarm_unit #(.HAS_SEC(1'b1)) u_alarm1 (
    .now_sec (now_sec), .now_min (now_min), .now_hour (now_hour),
    .now_wday(now_wday), .now_mday(now_mday),
    .cfg_sec (alm1_sec), .cfg_min (alm1_min), .cfg_hour (alm1_hour),
    .cfg_day (alm1_day), .unit_match (match1)
  );

  tod_alarm_unit #(.HAS_SEC(1'b0)) u_alarm2 (
    .now_sec (now_sec), .now_min (now_min), .now_hour (now_hour),
    .now_wday(now_wday), .now_mday(now_mday),
    .cfg_sec (8'h00), .cfg_min (alm2_min), .cfg_hour (alm2_hour),
    .cfg_day (alm2_day), .unit_match (match2)
  );

  // strobe gating: evaluation only on the update
  always_comb begin
    req1 = sec_tick & match1;
    req2 = sec_tick & match2;
  end

  if (OUT_STAGE) begin : g_staged
    logic hit1_q, hit2_q;
    logic hit1_d, hit2_d;

    always_comb begin
      hit1_d = req1;
      hit2_d = req2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit1_q <= 1'b0;
        hit2_q <= 1'b0;
      end else begin
        hit1_q <= hit1_d;
        hit2_q <= hit2_d;
      end
    end

    assign alm1_hit = hit1_q;
    assign alm2_hit = hit2_q;

    a_r1_staged_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (alm1_hit || alm2_hit) |-> $past(sec_tick));
  end else begin : g_direct
    assign alm1_hit = req1;
    assign alm2_hit = req2;

    a_r1_hit_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (alm1_hit || alm2_hit) |-> sec_tick);

    a_r6_a2_sec_zero: assert property (@(posedge clk) disable iff (!rst_n)
      alm2_hit |-> (now_sec[6:0] == 7'd0));

    a_r2_every_second: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && alm1_sec[7] && alm1_min[7] && alm1_hour[7] && alm1_day[7]) |-> alm1_hit);

    a_r3_sec_agrees: assert property (@(posedge clk) disable iff (!rst_n)
      (alm1_hit && !alm1_sec[7]) |-> (alm1_sec[6:0] == now_sec[6:0]));
  end
endmodule

// File: tb/tb_tod_alarm_match.sv
`timescale 1ns/1ps
module tb_tod_alarm_match;
  logic clk = 1'b0;
  logic rst_n;
  logic sec_tick;
  logic [7:0] now_sec, now_min, now_hour, now_wday, now_mday;
  logic [7:0] alm1_sec, alm1_min, alm1_hour, alm1_day;
  logic [7:0] alm2_min, alm2_hour, alm2_day;
  logic alm1_hit, alm2_hit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tod_alarm_match dut (.*);

  function automatic logic [7:0] rnd_bcd(int hi_tens);
    int t = $urandom_range(hi_tens, 0);
    int o = $urandom_range(9, 0);
    return {1'b0, 3'(t), 4'(o)};
  endfunction

  function automatic bit f7(logic [7:0] a, logic [7:0] n);
    return a[7] || (a[6:0] == n[6:0]);
  endfunction

  function automatic bit fday(logic [7:0] a, logic [7:0] wd, logic [7:0] md);
    logic [5:0] t = a[6] ? wd[5:0] : md[5:0];
    return a[7] || (a[5:0] == t);
  endfunction

  function automatic bit exp1();
    return sec_tick && f7(alm1_sec, now_sec) && f7(alm1_min, now_min) &&
           f7(alm1_hour, now_hour) && fday(alm1_day, now_wday, now_mday);
  endfunction

  function automatic bit exp2();
    return sec_tick && (now_sec[6:0] == 7'd0) && f7(alm2_min, now_min) &&
           f7(alm2_hour, now_hour) && fday(alm2_day, now_wday, now_mday);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive on negedge, check 1 ns later (outputs are same-cycle)
  task automatic step(string req);
    #1;
    chk({req, " a1"}, alm1_hit, exp1());
    chk({req, " a2"}, alm2_hit, exp2());
    @(negedge clk);
  endtask

  task automatic set_now(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                         logic [7:0] w, logic [7:0] d);
    now_sec = s; now_min = m; now_hour = h; now_wday = w; now_mday = d;
  endtask

  // mask pattern p: number of low fields unmasked
  function automatic logic [7:0] cfg(logic [7:0] now_v, bit masked, bit near);
    logic [7:0] v = now_v & 8'h7f;
    if (near) v[0] = ~v[0];
    return {masked, v[6:0]};
  endfunction

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0;
    set_now(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    alm1_sec = 8'h80; alm1_min = 8'h80; alm1_hour = 8'h80; alm1_day = 8'h80;
    alm2_min = 8'h80; alm2_hour = 8'h80; alm2_day = 8'h80;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state / no tick
    #1; chk("R1 reset a1", alm1_hit, 1'b0); chk("R1 reset a2", alm2_hit, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 every second, R6 once per minute
    sec_tick = 1; set_now(8'h37, 8'h12, 8'h05, 8'h03, 8'h21);
    #1; chk("R2 every sec", alm1_hit, 1'b1); chk("R6 sec!=0", alm2_hit, 1'b0);
    @(negedge clk);
    now_sec = 8'h00;
    #1; chk("R6 sec==0", alm2_hit, 1'b1); @(negedge clk);
    // R1 / R9: pulse drops without tick
    sec_tick = 0;
    #1; chk("R9 one cycle a1", alm1_hit, 1'b0); chk("R9 one cycle a2", alm2_hit, 1'b0);
    @(negedge clk);

    // R3 seconds only
    sec_tick = 1; set_now(8'h45, 8'h30, 8'h11, 8'h02, 8'h15);
    alm1_sec = 8'h45;
    #1; chk("R3 sec match", alm1_hit, 1'b1); @(negedge clk);
    alm1_sec = 8'h44;
    #1; chk("R3 sec miss", alm1_hit, 1'b0); @(negedge clk);

    // R8 current bit7 ignored, alarm value excludes mask
    alm1_sec = 8'h45; now_sec = 8'hC5;
    #1; chk("R8 now bit7", alm1_hit, 1'b1); @(negedge clk);

    // R4 min+sec and hour+min+sec
    now_sec = 8'h45; alm1_min = 8'h30;
    #1; chk("R4 min+sec", alm1_hit, 1'b1); @(negedge clk);
    alm1_hour = 8'h12;
    #1; chk("R4 hour miss", alm1_hit, 1'b0); @(negedge clk);
    alm1_hour = 8'h11;
    #1; chk("R4 hour match", alm1_hit, 1'b1); @(negedge clk);

    // R5 date vs weekday
    alm1_day = 8'h15;            // date 15
    #1; chk("R5 date match", alm1_hit, 1'b1); @(negedge clk);
    alm1_day = 8'h42;            // weekday 2
    #1; chk("R5 weekday match", alm1_hit, 1'b1); @(negedge clk);
    alm1_day = 8'h02;            // date 2 -> miss
    #1; chk("R5 date miss", alm1_hit, 1'b0); @(negedge clk);
    // R8: high bits of current day/date ignored
    now_wday = 8'hC2; alm1_day = 8'h42;
    #1; chk("R8 day high bits", alm1_hit, 1'b1); @(negedge clk);

    // R7 alarm 2 levels, R10 independence (alarm1 now missing)
    alm1_sec = 8'h01; now_sec = 8'h00;
    alm2_min = 8'h30;
    #1; chk("R7 a2 min", alm2_hit, 1'b1); chk("R10 a1 miss", alm1_hit, 1'b0); @(negedge clk);
    alm2_hour = 8'h11; alm2_day = 8'h42;
    #1; chk("R7 a2 full wday", alm2_hit, 1'b1); @(negedge clk);
    alm2_day = 8'h02;
    #1; chk("R7 a2 full date miss", alm2_hit, 1'b0); @(negedge clk);

    // random: listed mask patterns only
    for (int i = 0; i < 3000; i++) begin
      int p1 = $urandom_range(4, 0);
      int p2 = $urandom_range(3, 0);
      logic [7:0] dv;
      sec_tick = ($urandom_range(3, 0) != 0);
      set_now(($urandom_range(3,0)==0) ? 8'h00 : rnd_bcd(5), rnd_bcd(5),
              rnd_bcd(2), {5'b0, 3'($urandom_range(7, 1))}, rnd_bcd(3));
      alm1_sec  = cfg(now_sec,  p1 < 1, $urandom_range(4,0)==0);
      alm1_min  = cfg(now_min,  p1 < 2, $urandom_range(4,0)==0);
      alm1_hour = cfg(now_hour, p1 < 3, $urandom_range(4,0)==0);
      dv = $urandom_range(1,0) ? now_wday : now_mday;
      alm1_day  = {p1 < 4, (dv == now_wday) ? 1'b1 : 1'b0, dv[5:0] ^ {5'b0, $urandom_range(4,0)==0}};
      alm2_min  = cfg(now_min,  p2 < 1, $urandom_range(4,0)==0);
      alm2_hour = cfg(now_hour, p2 < 2, $urandom_range(4,0)==0);
      dv = $urandom_range(1,0) ? now_wday : now_mday;
      alm2_day  = {p2 < 3, (dv == now_wday) ? 1'b1 : 1'b0, dv[5:0] ^ {5'b0, $urandom_range(4,0)==0}};
      step("R2-R10 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule